// File: doc/BRIEF.md
# Four-Lane 7:1 Pixel Serializer

This block turns one 28-bit parallel pixel word per pixel period into four serial data lanes and one framing-clock lane. Everything runs on a bit clock at seven times the pixel rate, which is supplied from outside. The pixel clock comes in as an ordinary input and is sampled on that bit clock. A select input chooses whether a word is taken on the rising or the falling transition of the pixel clock. The captured word waits in a holding register. At the start of the next 7-bit slot it moves into four 7-bit shift registers, one for each lane.

The clock lane repeats a fixed 7-bit pattern once per slot, so a receiver can find where each slot starts. An external alignment pulse forces the slot counter back to position 0. A single active-low shutdown input clears every register to zero and silences all five outputs. When shutdown is released, the slot counter starts at position 0. The data lanes stay at zero until the first captured word has been loaded.

Top module: `pixel_serializer_tx`

## Requirements
- R1: With `sel_i` high, the word on `data_i` is captured in the bit-clock cycle where `pix_i` is first sampled high after being sampled low. Falling transitions capture nothing.
- R2: With `sel_i` low, the word is captured where `pix_i` is first sampled low after being sampled high. Rising transitions capture nothing.
- R3: Lane k (`lane_o[k]`, k = 0..3) carries word bits 7k to 7k+6. Bit 7k is sent at slot position 0 and the following bits go out in ascending order, one per bit clock.
- R4: The slot position counts 0,1,...,6 and wraps. `clk_lane_o` sends 1,1,0,0,0,1,1 for positions 0 to 6, so its period is seven bit clocks.
- R5: A captured word moves into the shift registers only when the slot position enters 0. A capture in the middle of a slot leaves the slice being sent unchanged.
- R6: A high `sync_i` makes the next slot position 0 and loads the held word at that point.
- R7: While `sd_n_i` is low, `lane_o` and `clk_lane_o` are 0 without waiting for a clock edge, and all internal state is cleared to zero.
- R8: After `sd_n_i` rises, the clock lane begins its pattern at slot position 0. The data lanes send zeros until a word captured after the release has been loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Bit clock, seven times the pixel rate |
| sd_n_i | input | 1 | Active-low shutdown and asynchronous clear |
| sync_i | input | 1 | Forces the slot position to 0 on the next edge |
| pix_i | input | 1 | Pixel clock, sampled on bclk_i |
| sel_i | input | 1 | Capture edge select: 1 rising, 0 falling |
| data_i | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Framing clock lane |

## Verification
The bound assertions check on every cycle:
- the slot sequence and its realignment by the pulse;
- that the holding register takes the word only on the selected transition;
- that the shift registers only shift inside a slot;
- that a full 28-bit load happens at the boundary;
- that the outputs are silent during shutdown.

Other behaviours show up only in the bench's scenarios:
- that the serial streams end to end return exactly the words that were driven, for both edge selections and several capture phases;
- that recovery stays correct across shutdown cycles and alignment pulses;
- that zeros are sent after a release.

The bench does this with a reference model and a deserializer that aligns on the clock-lane pattern.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    localparam int DEF_LANES = 4;
    localparam int DEF_SLICE = 7;
    // clock-lane pattern, bit i is sent at slot position i
    localparam logic [DEF_SLICE-1:0] DEF_CLK_PAT = 7'b1100011;
endpackage

// File: rtl/ptx_capture.sv
module ptx_capture #(
    parameter int WIDTH = 28
) (
    input  logic             bclk_i,
    input  logic             sd_n_i,
    input  logic             pix_i,
    input  logic             sel_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] hold_o
);
    typedef struct packed {
        logic             pix;
        logic [WIDTH-1:0] hold;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       rise_seen, fall_seen, take;

    always_comb begin
        st_d      = st_q;
        rise_seen = pix_i & ~st_q.pix;
        fall_seen = ~pix_i & st_q.pix;
        take      = sel_i ? rise_seen : fall_seen;
        st_d.pix  = pix_i;
        if (take) begin
            st_d.hold = data_i;
        end
    end

    always_ff @(posedge bclk_i or negedge sd_n_i) begin
        if (!sd_n_i) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hold_o = st_q.hold;
endmodule

// File: rtl/ptx_slot.sv
module ptx_slot #(
    parameter int SLICE = 7,
    localparam int SW = $clog2(SLICE)
) (
    input  logic          bclk_i,
    input  logic          sd_n_i,
    input  logic          sync_i,
    output logic [SW-1:0] slot_o,
    output logic          load_o
);
    logic [SW-1:0] slot_d, slot_q;

    always_comb begin
        if (sync_i || slot_q == SW'(SLICE - 1)) slot_d = '0;
        else                                    slot_d = slot_q + SW'(1);
        load_o = (slot_d == '0);
    end

    always_ff @(posedge bclk_i or negedge sd_n_i) begin
        if (!sd_n_i) slot_q <= '0;
        else         slot_q <= slot_d;
    end

    assign slot_o = slot_q;
endmodule

// File: rtl/ptx_lane.sv
module ptx_lane #(
    parameter int SLICE = 7
) (
    input  logic             bclk_i,
    input  logic             sd_n_i,
    input  logic             load_i,
    input  logic [SLICE-1:0] slice_i,
    output logic [SLICE-1:0] sh_o,
    output logic             bit_o
);
    logic [SLICE-1:0] sh_d, sh_q;

    always_comb begin
        if (load_i) sh_d = slice_i;
        else        sh_d = {1'b0, sh_q[SLICE-1:1]};
    end

    always_ff @(posedge bclk_i or negedge sd_n_i) begin
        if (!sd_n_i) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sh_o  = sh_q;
    assign bit_o = sh_q[0];
endmodule

// File: rtl/pixel_serializer_tx.sv
module pixel_serializer_tx
    import ptx_pkg::*;
#(
    parameter int               LANES   = DEF_LANES,
    parameter int               SLICE   = DEF_SLICE,
    parameter logic [SLICE-1:0] CLK_PAT = DEF_CLK_PAT,
    localparam int WORD = LANES * SLICE,
    localparam int SW   = $clog2(SLICE)
) (
    input  logic            bclk_i,
    input  logic            sd_n_i,
    input  logic            sync_i,
    input  logic            pix_i,
    input  logic            sel_i,
    input  logic [WORD-1:0] data_i,
    output logic [LANES-1:0] lane_o,
    output logic            clk_lane_o
);
    logic [WORD-1:0] hold_w;
    logic [WORD-1:0] sh_w;
    logic [SW-1:0]   slot_w;
    logic            load_w;

    ptx_capture #(.WIDTH(WORD)) u_cap (
        .bclk_i (bclk_i),
        .sd_n_i (sd_n_i),
        .pix_i  (pix_i),
        .sel_i  (sel_i),
        .data_i (data_i),
        .hold_o (hold_w)
    );

    ptx_slot #(.SLICE(SLICE)) u_slot (
        .bclk_i (bclk_i),
        .sd_n_i (sd_n_i),
        .sync_i (sync_i),
        .slot_o (slot_w),
        .load_o (load_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ptx_lane #(.SLICE(SLICE)) u_lane (
            .bclk_i  (bclk_i),
            .sd_n_i  (sd_n_i),
            .load_i  (load_w),
            .slice_i (hold_w[g*SLICE +: SLICE]),
            .sh_o    (sh_w[g*SLICE +: SLICE]),
            .bit_o   (lane_o[g])
        );
    end

    // framing lane: gated so it is silent at once when shutdown is asserted
    assign clk_lane_o = sd_n_i & CLK_PAT[slot_w];
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
    parameter int LANES = 4,
    parameter int SLICE = 7,
    localparam int WORD = LANES * SLICE,
    localparam int SW   = $clog2(SLICE)
) (
    input logic             bclk_i,
    input logic             sd_n_i,
    input logic             sync_i,
    input logic             pix_i,
    input logic             sel_i,
    input logic [WORD-1:0]  data_i,
    input logic [LANES-1:0] lane_o,
    input logic             clk_lane_o,
    input logic [SW-1:0]    slot,
    input logic [WORD-1:0]  hold,
    input logic [WORD-1:0]  sh
);
    logic pix_prev;
    always_ff @(posedge bclk_i or negedge sd_n_i) begin
        if (!sd_n_i) pix_prev <= 1'b0;
        else         pix_prev <= pix_i;
    end

    logic up_cap, dn_cap;
    assign up_cap = sel_i & pix_i & ~pix_prev;
    assign dn_cap = ~sel_i & ~pix_i & pix_prev;

    AST_CAPTURE_RISE: assert property (@(posedge bclk_i) disable iff (!sd_n_i) up_cap |=> hold == $past(data_i)); // R1
    AST_CAPTURE_FALL: assert property (@(posedge bclk_i) disable iff (!sd_n_i) dn_cap |=> hold == $past(data_i)); // R2
    AST_HOLD_STEADY:  assert property (@(posedge bclk_i) disable iff (!sd_n_i) (!up_cap && !dn_cap) |=> $stable(hold)); // R1
    AST_SLOT_WRAP:    assert property (@(posedge bclk_i) disable iff (!sd_n_i) (!sync_i && slot == SW'(SLICE - 1)) |=> slot == '0); // R4
    AST_SLOT_STEP:    assert property (@(posedge bclk_i) disable iff (!sd_n_i) (!sync_i && slot != SW'(SLICE - 1)) |=> slot == $past(slot) + SW'(1)); // R4
    AST_CLK_START:    assert property (@(posedge bclk_i) disable iff (!sd_n_i) slot == '0 |-> clk_lane_o); // R4
    AST_SYNC_ALIGN:   assert property (@(posedge bclk_i) disable iff (!sd_n_i) sync_i |=> slot == '0); // R6
    AST_LOAD_WORD:    assert property (@(posedge bclk_i) disable iff (!sd_n_i) (sync_i || slot == SW'(SLICE - 1)) |=> sh == $past(hold)); // R3
    AST_SHUT_QUIET:   assert property (@(posedge bclk_i) !sd_n_i |-> (lane_o == '0 && !clk_lane_o)); // R7

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_NO_MIDSLOT_LOAD: assert property (@(posedge bclk_i) disable iff (!sd_n_i)
            slot != '0 |-> sh[g*SLICE +: SLICE] == {1'b0, $past(sh[g*SLICE+1 +: SLICE-1])}); // R5
    end
endmodule

bind pixel_serializer_tx ptx_checker #(.LANES(LANES), .SLICE(SLICE)) u_chk (
    .bclk_i     (bclk_i),
    .sd_n_i     (sd_n_i),
    .sync_i     (sync_i),
    .pix_i      (pix_i),
    .sel_i      (sel_i),
    .data_i     (data_i),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o),
    .slot       (slot_w),
    .hold       (hold_w),
    .sh         (sh_w)
);

// File: tb/pixel_serializer_tx_tb.sv
module pixel_serializer_tx_tb;
    localparam int L = 4;
    localparam int S = 7;
    localparam int W = L * S;

    logic         bclk = 1'b0;
    logic         sd_n = 1'b1;
    logic         sync = 1'b0;
    logic         pix  = 1'b0;
    logic         sel  = 1'b1;
    logic [W-1:0] data = '0;
    wire  [L-1:0] lane;
    wire          clkl;

    always #4 bclk = ~bclk;

    pixel_serializer_tx u_dut (
        .bclk_i(bclk), .sd_n_i(sd_n), .sync_i(sync), .pix_i(pix),
        .sel_i(sel), .data_i(data), .lane_o(lane), .clk_lane_o(clkl)
    );

    int errors = 0;
    int checks = 0;
    int pat [7] = '{1, 1, 0, 0, 0, 1, 1};

    // behavioural reference model, advanced on each rising bit clock
    int           m_slot = 0;
    logic [W-1:0] m_cur = '0, m_held = '0;
    bit           m_valid = 0, m_loaded = 0;
    logic         m_pix = 1'b0;

    always @(posedge bclk) begin
        if (!sd_n) begin
            m_slot = 0; m_cur = '0; m_held = '0;
            m_valid = 0; m_loaded = 0; m_pix = 1'b0;
        end else begin
            int nxt;
            nxt = (sync || m_slot == S - 1) ? 0 : m_slot + 1;
            if (nxt == 0) begin
                m_cur = m_held;
                if (m_valid) m_loaded = 1;
            end
            if (pix != m_pix && (sel ? pix : !pix)) begin
                m_held  = data;
                m_valid = 1;
            end
            m_pix  = pix;
            m_slot = nxt;
        end
    end

    bit           sync_phase = 0;
    bit           des_on = 0;
    string        cur_tag = "R1";
    logic [W-1:0] exp_q [$];
    int           recovered = 0;
    int           ph = 0;
    logic [6:0]   h_clk = '0;
    logic [6:0]   h_lane [L];

    task automatic fail(string req, string what, logic [31:0] act, logic [31:0] exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    task automatic check_cycle();
        logic [L-1:0] e_lane;
        logic         e_clk;
        string        tl, tc;
        for (int l = 0; l < L; l++) e_lane[l] = m_cur[l*S + m_slot];
        e_clk = sd_n ? pat[m_slot][0] : 1'b0;
        if (!sd_n)           begin tl = "R7"; tc = "R7"; end
        else if (sync_phase) begin tl = "R6"; tc = "R6"; end
        else if (!m_loaded)  begin tl = "R8"; tc = "R8"; end
        else                 begin tl = "R3"; tc = "R4"; end
        checks++;
        if (lane !== e_lane) fail(tl, "data lanes", 32'(lane), 32'(e_lane));
        checks++;
        if (clkl !== e_clk) fail(tc, "clock lane", 32'(clkl), 32'(e_clk));
    endtask

    // deserializer: a clock-lane history of 0,1,1 marks slot position 6
    task automatic deser();
        logic [W-1:0] word;
        h_clk = {h_clk[5:0], clkl};
        for (int l = 0; l < L; l++) h_lane[l] = {h_lane[l][5:0], lane[l]};
        if (des_on && h_clk[0] && h_clk[1] && !h_clk[2]) begin
            for (int l = 0; l < L; l++)
                for (int k = 0; k < S; k++) word[l*S + k] = h_lane[l][6-k];
            if (word != '0) begin
                checks++;
                if (exp_q.size() == 0) fail(cur_tag, "unexpected word", 32'(word), 32'(0));
                else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    if (word !== e) fail(cur_tag, "recovered word", 32'(word), 32'(e));
                    recovered++;
                end
            end
        end
    endtask

    task automatic drive(int r);
        logic nxt;
        nxt  = ((ph - r + 7) % 7) < 4;
        data = W'($urandom());
        if (nxt != pix && (sel ? nxt : !nxt)) exp_q.push_back(data);
        pix = nxt;
        ph  = (ph + 1) % 7;
    endtask

    task automatic step(int r);
        @(negedge bclk);
        check_cycle();
        deser();
        drive(r);
    endtask

    task automatic shutdown(int n, bit new_sel);
        @(negedge bclk);
        check_cycle();
        deser();
        sd_n = 1'b0;
        pix  = 1'b0;
        #1;
        checks++;   // R7: outputs silent without a clock edge
        if (lane !== '0 || clkl !== 1'b0) fail("R7", "outputs at shutdown", 32'({lane, clkl}), 32'(0));
        repeat (n) begin
            @(negedge bclk);
            check_cycle();
            deser();
        end
        exp_q.delete();
        h_clk = '0;
        for (int l = 0; l < L; l++) h_lane[l] = '0;
        sel  = new_sel;
        ph   = 0;
        sd_n = 1'b1;
    endtask

    task automatic run(int r, int n, string tag);
        int need;
        des_on    = 1;
        cur_tag   = tag;
        recovered = 0;
        repeat (n) step(r);
        need = n / 7 - 3;
        checks++;
        if (recovered < need) fail(tag, "too few words", 32'(recovered), 32'(need));
        des_on = 0;
    endtask

    initial begin
        for (int l = 0; l < L; l++) h_lane[l] = '0;
        #1 sd_n = 1'b0;
        repeat (8) begin
            @(negedge bclk);
            checks++;   // R7 reset state
            if (lane !== '0 || clkl !== 1'b0) fail("R7", "reset state", 32'({lane, clkl}), 32'(0));
            check_cycle();
        end
        sel  = 1'b1;
        ph   = 0;
        sd_n = 1'b1;
        run(0, 280, "R1");
        shutdown(10, 1'b0);
        run(3, 280, "R2 R5");
        shutdown(10, 1'b1);
        run(5, 280, "R1 R5");
        shutdown(10, 1'b0);
        sync_phase = 1;
        for (int i = 0; i < 200; i++) begin
            step(2);
            sync = (i == 50 || i == 123);
        end
        sync_phase = 0;
        shutdown(10, 1'b1);
        run(1, 140, "R1 R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule